// File: doc/BRIEF.md
# Firmware Hub Read Initiator

This block is the host side of a nibble-wide firmware hub bus, and it only performs read cycles. A request carries a target select nibble, a 28-bit address and a size code. Once the block accepts a request, it drives the cycle on the shared 4-bit bus. The strobe is held low only for the opening nibble. The block then sends the target select, the address and the size, hands the bus over after one turnaround nibble, and watches the target's sync nibbles. The data nibbles that follow are paired into bytes and sent out on a byte stream.

The request side is valid/ready. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The fields must be stable in that cycle. The byte stream has no back-pressure, because the target sets the pace of the bus and cannot be stalled. The sink must therefore take every cycle in which `rd_valid` is high. The final byte of a burst has `rd_last` set. After the target's closing turnaround and release, the block pulses `done` and becomes ready again. If no ready sync arrives within `TIMEOUT` sync cycles, the block gives up and pulses `done` together with `err`.

Top module: `fwh_rd_init`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `frame_n`=1, `bus_oe`=0, `rd_valid`=0, `done`=0, `err`=0.
- R2: A request is accepted only when `req_ready` is high. In the cycle after acceptance, `frame_n` is 0, `bus_oe` is 1 and `bus_out` is 4'b1101. `req_ready` stays low until the cycle is over.
- R3: `frame_n` is low for exactly that one opening cycle and high in every other cycle.
- R4: The next cycle carries the target select nibble. The 7 cycles after that carry the address nibbles, most significant nibble (bits 27:24) first.
- R5: The size nibble follows the address. After it, the block drives one cycle of 4'b1111 with `bus_oe`=1. `bus_oe` is then 0 until the next request's opening cycle.
- R6: While the bus is released, the block treats any nibble other than 4'b0000 (normally the wait code 4'b0101) as a wait. A 4'b0000 means that the first data nibble is on the bus in the next cycle.
- R7: The burst is 2^size bytes, for size codes 0000b, 0001b, 0010b, 0100b and 0111b (1, 2, 4, 16 and 128 bytes). Each byte is built from two successive nibbles, and the first nibble becomes bits 3:0. Each byte appears for one cycle on `rd_data` with `rd_valid`, and `rd_last` is set only on the final byte.
- R8: After the last data nibble, the block spends two cycles while the target drives 4'b1111 and then floats the bus. In the following cycle `done` pulses for one cycle and `req_ready` is 1 again.
- R9: If `TIMEOUT` consecutive sync cycles pass with no 4'b0000, `done` and `err` pulse together in the cycle after the last of them, and the block becomes idle. A 4'b0000 in that last sync cycle still starts the data phase.
- R10: `err` stays 0 when a cycle ends normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_id | input | 4 | Target select nibble |
| req_addr | input | 28 | Read start address |
| req_size | input | 4 | Size code (burst of 2^code bytes) |
| frame_n | output | 1 | Cycle start strobe, active low |
| bus_out | output | 4 | Nibble driven onto the bus |
| bus_oe | output | 1 | Host drives the bus when high |
| bus_in | input | 4 | Nibble read from the bus (pulled high when floating) |
| rd_valid | output | 1 | Data byte present |
| rd_data | output | 8 | Assembled data byte |
| rd_last | output | 1 | Final byte of the burst |
| done | output | 1 | One-cycle pulse at the end of a cycle |
| err | output | 1 | Sync timeout, pulses with done |

## Verification
The assertions assume the following about the inputs:
- Requests carry one of the five legal size codes.
- A target answers only while the bus is released.
- The closing turnaround is supplied by the target, not checked.

The bench acts as that target. It drives each nibble half a clock before the edge that samples it. It uses only legal size codes, puts the pulled-up value on the bus while idle, and lengthens the wait phase up to and past the timeout boundary.

// File: rtl/fwh_pkg.sv
package fwh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_TAR0, ST_TAR1, ST_SYNC, ST_DATA, ST_CTAR0, ST_CTAR1
  } fwh_state_e;

  localparam int NIB_W = 4;
  localparam logic [NIB_W-1:0] NIB_START = 4'hD;
  localparam logic [NIB_W-1:0] NIB_TAR   = 4'hF;
  localparam logic [NIB_W-1:0] NIB_READY = 4'h0;
endpackage

// File: rtl/fwh_hdr_mux.sv
module fwh_hdr_mux
  import fwh_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [NIB_W-1:0]  id,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NIB_W-1:0]  size,
  output logic [NIB_W-1:0]  nib
);
  localparam int ADDR_NIBS = ADDR_W / NIB_W;

  logic [NIB_W-1:0] addr_nib [ADDR_NIBS];

  // most significant nibble at position 0
  for (genvar g = 0; g < ADDR_NIBS; g++) begin : g_split
    assign addr_nib[g] = addr[ADDR_W-1-NIB_W*g -: NIB_W];
  end

  always_comb begin
    nib = size;
    if (idx == IDX_W'(0)) nib = NIB_START;
    else if (idx == IDX_W'(1)) nib = id;
    for (int k = 0; k < ADDR_NIBS; k++) begin
      if (idx == IDX_W'(k + 2)) nib = addr_nib[k];
    end
  end
endmodule

// File: rtl/fwh_sync_timer.sv
module fwh_sync_timer #(
  parameter int TIMEOUT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TO_W = $clog2(TIMEOUT + 1);

  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + TO_W'(1);
    else          cnt <= '0;
  end

  assign expired = run && (cnt == TO_W'(TIMEOUT - 1));
endmodule

// File: rtl/fwh_byte_pack.sv
module fwh_byte_pack
  import fwh_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] nbytes_m1,
  input  logic             nib_en,
  input  logic [NIB_W-1:0] nib,
  output logic             final_nib,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             byte_last
);
  logic             phase;
  logic [NIB_W-1:0] low_q;
  logic [CNT_W-1:0] cnt;
  logic             last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= 1'b0;
      low_q      <= '0;
      cnt        <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      last_q     <= 1'b0;
    end else if (clear) begin
      phase      <= 1'b0;
      cnt        <= '0;
      byte_valid <= 1'b0;
      last_q     <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (nib_en) begin
        if (!phase) begin
          low_q <= nib;
          phase <= 1'b1;
        end else begin
          byte_data  <= {nib, low_q};
          byte_valid <= 1'b1;
          last_q     <= (cnt == nbytes_m1);
          cnt        <= cnt + CNT_W'(1);
          phase      <= 1'b0;
        end
      end
    end
  end

  assign final_nib = nib_en && phase && (cnt == nbytes_m1);
  assign byte_last = byte_valid && last_q;
endmodule

// File: rtl/fwh_rd_init.sv
module fwh_rd_init
  import fwh_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int TIMEOUT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  output logic              frame_n,
  output logic [3:0]        bus_out,
  output logic              bus_oe,
  input  logic [3:0]        bus_in,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              rd_last,
  output logic              done,
  output logic              err
);
  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int HDR_LEN   = ADDR_NIBS + 3;
  localparam int IDX_W     = $clog2(HDR_LEN + 1);
  localparam int CNT_W     = 8;

  fwh_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic [NIB_W-1:0]  id_q, size_q, hdr_nib;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  nbytes_m1;
  logic              accept, expired, final_nib;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign nbytes_m1 = (CNT_W'(1) << size_q[2:0]) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      id_q   <= '0;
      addr_q <= '0;
      size_q <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          id_q   <= req_id;
          addr_q <= req_addr;
          size_q <= req_size;
          idx    <= '0;
          state  <= ST_HDR;
        end
        ST_HDR: begin
          if (idx == IDX_W'(HDR_LEN - 1)) state <= ST_TAR0;
          else idx <= idx + IDX_W'(1);
        end
        ST_TAR0: state <= ST_TAR1;
        ST_TAR1: state <= ST_SYNC;
        ST_SYNC: begin
          if (bus_in == NIB_READY) state <= ST_DATA;
          else if (expired) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            err   <= 1'b1;
          end
        end
        ST_DATA:  if (final_nib) state <= ST_CTAR0;
        ST_CTAR0: state <= ST_CTAR1;
        ST_CTAR1: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  fwh_hdr_mux #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hdr (
    .idx(idx), .id(id_q), .addr(addr_q), .size(size_q), .nib(hdr_nib)
  );

  fwh_sync_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SYNC), .expired(expired)
  );

  fwh_byte_pack #(.CNT_W(CNT_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(accept), .nbytes_m1(nbytes_m1),
    .nib_en(state == ST_DATA), .nib(bus_in), .final_nib(final_nib),
    .byte_valid(rd_valid), .byte_data(rd_data), .byte_last(rd_last)
  );

  assign frame_n = !((state == ST_HDR) && (idx == '0));
  assign bus_oe  = (state == ST_HDR) || (state == ST_TAR0);
  assign bus_out = (state == ST_HDR) ? hdr_nib : NIB_TAR;
endmodule

// File: rtl/fwh_rd_init_chk.sv
module fwh_rd_init_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       frame_n,
  input logic [3:0] bus_out,
  input logic       bus_oe,
  input logic       rd_valid,
  input logic       rd_last,
  input logic       done,
  input logic       err
);
  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !frame_n && bus_oe && bus_out == 4'hD);
  // R2
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> !req_ready);
  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> frame_n);
  // R5
  released_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> frame_n);
  // R7
  nothing_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_last |=> !rd_valid);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && !bus_oe);
  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind fwh_rd_init fwh_rd_init_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .frame_n(frame_n), .bus_out(bus_out), .bus_oe(bus_oe),
  .rd_valid(rd_valid), .rd_last(rd_last), .done(done), .err(err)
);

// File: tb/tb_fwh_rd_init.sv
module tb_fwh_rd_init;
  localparam int TO = 12;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready;
  logic [3:0]  req_id = 0, req_size = 0;
  logic [27:0] req_addr = 0;
  logic        frame_n, bus_oe, rd_valid, rd_last, done, err;
  logic [3:0]  bus_out, bus_in = 4'hF;
  logic [7:0]  rd_data;

  int checks = 0, failures = 0, cycles = 0;
  logic [7:0] got_data [256];
  logic       got_last [256];
  int         got_n = 0;

  fwh_rd_init #(.ADDR_W(28), .TIMEOUT(TO)) dut (.*);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (rd_valid && got_n < 256) begin
      got_data[got_n] = rd_data;
      got_last[got_n] = rd_last;
      got_n++;
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_header(input [3:0] id, input [27:0] addr, input [3:0] size);
    @(negedge clk);
    chk(req_ready == 1, "R2 ready when idle", req_ready, 1);
    req_valid = 1; req_id = id; req_addr = addr; req_size = size;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 10; i++) begin
      logic [3:0] e;
      if (i == 0) e = 4'hD;
      else if (i == 1) e = id;
      else if (i < 9) e = addr[27-4*(i-2) -: 4];
      else e = size;
      chk(bus_out == e && bus_oe, (i == 0) ? "R2 start nibble" : "R4 header nibble", bus_out, e);
      chk(frame_n == (i != 0), "R3 strobe", frame_n, i != 0);
      if (i == 0) chk(req_ready == 0, "R2 busy", req_ready, 0);
      @(negedge clk);
    end
    chk(bus_oe && bus_out == 4'hF, "R5 host turnaround", {bus_oe, bus_out}, 5'h1F);
    @(negedge clk);
    chk(!bus_oe && frame_n, "R5 released", bus_oe, 0);
    bus_in = 4'hF;
    @(negedge clk);
  endtask

  task automatic do_read(input [3:0] id, input [27:0] addr, input [3:0] size,
                         input int waits, input [7:0] seed, input [3:0] wcode);
    int nb;
    nb = 1 << size[2:0];
    got_n = 0;
    send_header(id, addr, size);
    for (int w = 0; w < waits; w++) begin
      bus_in = wcode;
      @(negedge clk);
    end
    bus_in = 4'h0;
    @(negedge clk);
    chk(got_n == 0 && !bus_oe, "R6 no data during sync", got_n, 0);
    for (int b = 0; b < nb; b++) begin
      logic [7:0] v;
      v = seed + 8'(b * 37);
      bus_in = v[3:0];
      @(negedge clk);
      bus_in = v[7:4];
      @(negedge clk);
    end
    bus_in = 4'hF;
    chk(done == 0, "R8 no early done", done, 0);
    @(negedge clk);
    chk(done == 0 && !bus_oe, "R8 target release", done, 0);
    @(negedge clk);
    chk(done == 1 && req_ready == 1, "R8 done pulse", {done, req_ready}, 2'b11);
    chk(err == 0, "R10 no error", err, 0);
    @(negedge clk);
    chk(done == 0, "R8 single pulse", done, 0);
    chk(got_n == nb, "R7 byte count", got_n, nb);
    for (int b = 0; b < nb && b < got_n; b++) begin
      logic [7:0] v;
      v = seed + 8'(b * 37);
      chk(got_data[b] == v, "R7 byte value", got_data[b], v);
      chk(got_last[b] == (b == nb - 1), "R7 last flag", got_last[b], b == nb - 1);
    end
  endtask

  task automatic do_timeout();
    send_header(4'h3, 28'h0ABCDEF, 4'h0);
    for (int s = 1; s <= TO; s++) begin
      chk(done == 0, "R9 still waiting", done, 0);
      bus_in = 4'h5;
      @(negedge clk);
    end
    chk(done && err, "R9 timeout", {done, err}, 2'b11);
    chk(req_ready == 1 && got_n == 0, "R9 idle after timeout", req_ready, 1);
    bus_in = 4'hF;
    @(negedge clk);
    chk(!done && !err, "R9 single pulse", {done, err}, 0);
  endtask

  initial begin
    @(negedge clk);
    chk(req_ready && frame_n && !bus_oe && !rd_valid && !done && !err,
        "R1 reset state", {req_ready, frame_n, bus_oe, rd_valid, done, err}, 6'b110000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && frame_n && !bus_oe, "R1 idle after reset", req_ready, 1);
    do_read(4'h0, 28'h1234567, 4'h0, 2, 8'h5A, 4'h5);
    do_read(4'hA, 28'hFEDCBA9, 4'h1, 2, 8'h01, 4'h5);
    do_read(4'h5, 28'h8000001, 4'h2, 0, 8'hC3, 4'h5);
    do_read(4'hF, 28'h0F0F0F0, 4'h4, 5, 8'h77, 4'h6);
    do_read(4'h7, 28'h7654321, 4'h7, 2, 8'h10, 4'h5);
    do_read(4'h2, 28'h0000000, 4'h1, TO - 1, 8'hEE, 4'h5);
    got_n = 0;
    do_timeout();
    do_read(4'h9, 28'hABCDEF0, 4'h0, 1, 8'h3C, 4'h5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule